// File: doc/BRIEF.md
# Page-wrapping EEPROM address counter

This block keeps the word pointer of a 256-byte serial EEPROM. It also stages write data in a 16-byte page buffer and copies that buffer into the storage array. A protocol controller sits in front of it. That controller decodes the serial bus and hands this block single-cycle strobes: load a word address, a data byte arrived from the master, a data byte was shifted out to the master, and the write sequence ended with a stop.

The pointer steps in two different ways. After a received byte, only its low nibble counts, so a long write burst wraps inside one 16-byte page and the newest bytes replace the oldest ones. After a sent byte, the whole pointer counts, so a sequential read runs across page boundaries and wraps from the top of the array back to address zero. Each received byte lands in the buffer slot given by the low nibble of the pointer, and that slot is marked valid. On a commit, a sequencer walks the 16 slots one per cycle. It writes only the valid slots into the page the pointer sits in, then drops every valid mark. The array read port always presents the byte under the pointer, one cycle after the pointer settles.

Top module: `pgw_addr_unit`

## Requirements
- R1: After a synchronous reset, `ptr` is 0x00, `busy` is low, and no buffer slot is valid.
- R2: When the block is idle, `addr_load` puts `addr_in` into `ptr` at the next clock edge and discards any staged, uncommitted bytes. A load has priority over a write strobe, and a write strobe has priority over a read strobe.
- R3: `wr_byte_stb` stores `wr_byte` in buffer slot `ptr[3:0]` and marks that slot valid. It then increments `ptr[3:0]` modulo 16 while `ptr[7:4]` stays unchanged (for example 0xFF becomes 0xF0).
- R4: If more than 16 bytes are received in one sequence, the page ends up holding the last 16 bytes received, each at its wrapped offset.
- R5: `rd_byte_stb` increments the full 8-bit `ptr` modulo 256. It crosses page boundaries (0x4F becomes 0x50) and wraps 0xFF to 0x00.
- R6: `rd_data` equals the array byte at the address `ptr` held one clock edge earlier.
- R7: A `commit_req` while bytes are staged raises `busy` for exactly 16 cycles, starting at the next edge. During that time it writes each valid slot at offset o to address {ptr[7:4], o}. Bytes of the page that were not staged keep their old values, and all valid marks are cleared at the end.
- R8: A `commit_req` with no staged bytes leaves `busy` low, the array untouched and `ptr` at the loaded address.
- R9: While `busy` is high, `addr_load`, `wr_byte_stb`, `rd_byte_stb` and `commit_req` have no effect on `ptr`, on the buffer or on the array.
- R10: With no strobe present, `ptr` holds its value across any number of cycles. A current-address read therefore resumes after the last location accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load `addr_in` into the pointer |
| addr_in | input | 8 | Word address from the controller |
| wr_byte_stb | input | 1 | A data byte was received |
| wr_byte | input | 8 | Received data byte |
| rd_byte_stb | input | 1 | A data byte was sent |
| commit_req | input | 1 | Stop seen after a write sequence |
| ptr | output | 8 | Current word pointer |
| rd_data | output | 8 | Array byte under the pointer (registered) |
| busy | output | 1 | Commit sequence in progress |

## Verification
The pointer-step properties assume that a read strobe does not arrive in the same cycle as a load or a write strobe. They also assume that `commit_req` does not coincide with a pointer strobe, since the page captured for a commit would otherwise be ambiguous. The stimulus pulses one strobe at a time and waits for `busy` to fall between sequences. The one exception is a deliberate burst of strobes issued while a commit is running, which tests that those strobes are ignored. The bench keeps its own model of the array, the staged page and the pointer, and reads every committed page back through the normal read path.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int ADDR_W_DEF = 8;
  localparam int PAGE_W_DEF = 4;
  localparam int DATA_W_DEF = 8;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/pgw_pointer.sv
module pgw_pointer #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              wr_step,
  input  logic              rd_step,
  output logic [ADDR_W-1:0] ptr
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic [HI_W-1:0]   hi_q;
  logic [PAGE_W-1:0] lo_q;

  // low nibble steps alone on writes, whole pointer carries on reads
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_en) begin
      {hi_q, lo_q} <= load_val;
    end else if (wr_step) begin
      lo_q <= lo_q + PAGE_W'(1);
    end else if (rd_step) begin
      {hi_q, lo_q} <= {hi_q, lo_q} + ADDR_W'(1);
    end
  end

  assign ptr = {hi_q, lo_q};
endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [PAGE_W-1:0]     wr_off,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  clr_all,
  input  logic [PAGE_W-1:0]     rd_off,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic                  any_valid
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  vld_q;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_off == PAGE_W'(i));

    always_ff @(posedge clk) begin
      if (hit) slot_q[i] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst || clr_all) vld_q[i] <= 1'b0;
      else if (hit)       vld_q[i] <= 1'b1;
    end
  end

  assign rd_data   = slot_q[rd_off];
  assign rd_valid  = vld_q[rd_off];
  assign any_valid = |vld_q;
endmodule

// File: rtl/pgw_commit_seq.sv
module pgw_commit_seq
  import pgw_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int HI_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [HI_W-1:0]   page_in,
  input  logic              slot_valid,
  output logic              busy,
  output logic [PAGE_W-1:0] off,
  output logic [HI_W-1:0]   page,
  output logic              mem_we,
  output logic              clr_all
);
  localparam logic [PAGE_W-1:0] LAST = '1;

  seq_state_t        state_q;
  logic [PAGE_W-1:0] off_q;
  logic [HI_W-1:0]   page_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      off_q   <= '0;
      page_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_RUN;
            off_q   <= '0;
            page_q  <= page_in;
          end
        end
        default: begin
          off_q <= off_q + PAGE_W'(1);
          if (off_q == LAST) state_q <= SEQ_IDLE;
        end
      endcase
    end
  end

  assign busy    = (state_q == SEQ_RUN);
  assign off     = off_q;
  assign page    = page_q;
  assign mem_we  = busy && slot_valid;
  assign clr_all = busy && (off_q == LAST);
endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/pgw_addr_unit.sv
module pgw_addr_unit
  import pgw_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int PAGE_W = PAGE_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_byte_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_byte_stb,
  input  logic              commit_req,
  output logic [ADDR_W-1:0] ptr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic              idle;
  logic              load_go, wr_go, rd_go, start_go;
  logic              any_valid, slot_valid, clr_seq, mem_we;
  logic [PAGE_W-1:0] seq_off;
  logic [HI_W-1:0]   seq_page;
  logic [DATA_W-1:0] slot_data;

  assign idle     = !busy;
  assign load_go  = idle && addr_load;
  assign wr_go    = idle && wr_byte_stb && !addr_load;
  assign rd_go    = idle && rd_byte_stb && !addr_load && !wr_byte_stb;
  assign start_go = idle && commit_req && any_valid;

  pgw_pointer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_go),
    .load_val (addr_in),
    .wr_step  (wr_go),
    .rd_step  (rd_go),
    .ptr      (ptr)
  );

  pgw_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_go),
    .wr_off    (ptr[PAGE_W-1:0]),
    .wr_data   (wr_byte),
    .clr_all   (clr_seq || load_go),
    .rd_off    (seq_off),
    .rd_data   (slot_data),
    .rd_valid  (slot_valid),
    .any_valid (any_valid)
  );

  pgw_commit_seq #(.PAGE_W(PAGE_W), .HI_W(HI_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start_go),
    .page_in    (ptr[ADDR_W-1:PAGE_W]),
    .slot_valid (slot_valid),
    .busy       (busy),
    .off        (seq_off),
    .page       (seq_page),
    .mem_we     (mem_we),
    .clr_all    (clr_seq)
  );

  pgw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr ({seq_page, seq_off}),
    .wdata (slot_data),
    .raddr (ptr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/pgw_addr_unit_chk.sv
module pgw_addr_unit_chk #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_load,
  input logic [ADDR_W-1:0] addr_in,
  input logic              wr_byte_stb,
  input logic              rd_byte_stb,
  input logic              commit_req,
  input logic [ADDR_W-1:0] ptr,
  input logic              busy,
  input logic              any_valid
);
  localparam int SLOTS = 1 << PAGE_W;
  localparam int CNT_W = PAGE_W + 1;

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + CNT_W'(1);
  end

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (addr_load && !busy) |=> (ptr == $past(addr_in)));

  p_page_step_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_byte_stb && !addr_load && !busy) |=>
      (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])) &&
      (ptr[PAGE_W-1:0] == PAGE_W'($past(ptr[PAGE_W-1:0]) + 1)));

  p_read_step_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_byte_stb && !wr_byte_stb && !addr_load && !busy) |=>
      (ptr == ADDR_W'($past(ptr) + 1)));

  p_commit_len_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && busy_cnt == CNT_W'(SLOTS - 1)) |=> !busy);

  p_commit_start_r7: assert property (@(posedge clk) disable iff (rst)
    (commit_req && !busy && any_valid) |=> busy);

  p_empty_commit_r8: assert property (@(posedge clk) disable iff (rst)
    (commit_req && !busy && !any_valid) |=> !busy);

  p_busy_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ptr));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!addr_load && !wr_byte_stb && !rd_byte_stb) |=> $stable(ptr));
endmodule

bind pgw_addr_unit pgw_addr_unit_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_load   (addr_load),
  .addr_in     (addr_in),
  .wr_byte_stb (wr_byte_stb),
  .rd_byte_stb (rd_byte_stb),
  .commit_req  (commit_req),
  .ptr         (ptr),
  .busy        (busy),
  .any_valid   (any_valid)
);

// File: tb/pgw_addr_unit_test.sv
module pgw_addr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addr_load = 1'b0;
  logic [7:0] addr_in = '0;
  logic       wr_byte_stb = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       rd_byte_stb = 1'b0;
  logic       commit_req = 1'b0;
  logic [7:0] ptr;
  logic [7:0] rd_data;
  logic       busy;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [7:0] m_mem [256];
  logic [7:0] m_pend [16];
  bit         m_pv [16];
  logic [7:0] m_ptr;

  pgw_addr_unit uut (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
    .wr_byte_stb(wr_byte_stb), .wr_byte(wr_byte), .rd_byte_stb(rd_byte_stb),
    .commit_req(commit_req), .ptr(ptr), .rd_data(rd_data), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] a);
    addr_in = a; addr_load = 1'b1;
    @(negedge clk);
    addr_load = 1'b0;
    m_ptr = a;
    for (int i = 0; i < 16; i++) m_pv[i] = 0;
  endtask

  task automatic put(input logic [7:0] d);
    wr_byte = d; wr_byte_stb = 1'b1;
    @(negedge clk);
    wr_byte_stb = 1'b0;
    m_pend[m_ptr[3:0]] = d;
    m_pv[m_ptr[3:0]] = 1;
    m_ptr = {m_ptr[7:4], m_ptr[3:0] + 4'd1};
  endtask

  task automatic rd_next(input string tag);
    rd_byte_stb = 1'b1;
    @(negedge clk);
    rd_byte_stb = 1'b0;
    m_ptr = m_ptr + 8'd1;
    chk({tag, " ptr"}, ptr, m_ptr);
    @(negedge clk);
    chk({tag, " rd_data"}, rd_data, m_mem[m_ptr]);
  endtask

  task automatic commit_wait(input string tag, input bit expect_run);
    int n;
    bit anyv;
    commit_req = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
    anyv = 0;
    for (int o = 0; o < 16; o++) if (m_pv[o]) begin
      anyv = 1;
      m_mem[{m_ptr[7:4], 4'(o)}] = m_pend[o];
    end
    for (int o = 0; o < 16; o++) m_pv[o] = 0;
    chk({tag, " busy after commit"}, busy, expect_run);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk({tag, " busy cycles"}, n, expect_run ? 16 : 0);
  endtask

  task automatic read_at(input logic [7:0] a, input string tag);
    load(a);
    @(negedge clk);
    chk({tag, " rd_data"}, rd_data, m_mem[a]);
  endtask

  task automatic read_page(input logic [7:0] base, input string tag);
    read_at(base, tag);
    for (int i = 1; i < 16; i++) rd_next(tag);
  endtask

  task automatic t_reset();
    chk("R1 reset ptr", ptr, 8'h00);
    chk("R1 reset busy", busy, 1'b0);
    commit_req = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
    chk("R1 nothing staged after reset", busy, 1'b0);
  endtask

  task automatic t_write_small();
    load(8'h35);
    chk("R2 load ptr", ptr, 8'h35);
    put(8'hA1); chk("R3 ptr step 1", ptr, 8'h36);
    put(8'hA2); chk("R3 ptr step 2", ptr, 8'h37);
    put(8'hA3); chk("R3 ptr step 3", ptr, 8'h38);
    commit_wait("R7 small", 1);
    chk("R7 ptr kept after commit", ptr, 8'h38);
    read_at(8'h35, "R6 first byte");
    rd_next("R5 R6 seq");
    rd_next("R5 R6 seq");
  endtask

  task automatic t_page_wrap();
    load(8'h4E);
    for (int i = 0; i < 20; i++) put(8'h10 + 8'(i));
    chk("R4 ptr after 20 bytes", ptr, 8'h42);
    commit_wait("R4 wrap", 1);
    read_page(8'h40, "R4 page");
    chk("R4 offset 2 holds byte 4", m_mem[8'h42], 8'h14);
  endtask

  task automatic t_partial();
    load(8'h45);
    put(8'hB5); put(8'hB6);
    commit_wait("R7 partial", 1);
    read_page(8'h40, "R7 unstaged kept");
  endtask

  task automatic t_empty();
    load(8'h47);
    commit_wait("R8 empty", 0);
    chk("R8 ptr stays", ptr, 8'h47);
    @(negedge clk);
    chk("R8 array kept", rd_data, m_mem[8'h47]);
  endtask

  task automatic t_read_wrap();
    load(8'h00); put(8'h5A); commit_wait("R7 low", 1);
    load(8'hFF); put(8'hC3);
    chk("R3 page wrap FF to F0", ptr, 8'hF0);
    commit_wait("R7 top", 1);
    read_at(8'hFE, "R5 setup");
    rd_next("R5 to FF");
    rd_next("R5 FF to 00");
    chk("R5 wrapped ptr", ptr, 8'h00);
    load(8'h4F);
    rd_byte_stb = 1'b1;
    @(negedge clk);
    rd_byte_stb = 1'b0;
    chk("R5 cross page", ptr, 8'h50);
  endtask

  task automatic t_busy_ignore();
    load(8'h36); put(8'h77);
    commit_req = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
    m_mem[8'h36] = 8'h77;
    m_pv[6] = 0;
    chk("R9 busy", busy, 1'b1);
    wr_byte = 8'hEE; wr_byte_stb = 1'b1; @(negedge clk); wr_byte_stb = 1'b0;
    rd_byte_stb = 1'b1; @(negedge clk); rd_byte_stb = 1'b0;
    addr_in = 8'h99; addr_load = 1'b1; @(negedge clk); addr_load = 1'b0;
    commit_req = 1'b1; @(negedge clk); commit_req = 1'b0;
    chk("R9 ptr frozen", ptr, 8'h37);
    while (busy) @(negedge clk);
    chk("R9 ptr after commit", ptr, 8'h37);
    @(negedge clk);
    chk("R9 no stray write at 37", rd_data, 8'hA3);
    commit_req = 1'b1; @(negedge clk); commit_req = 1'b0;
    chk("R9 stray byte not staged", busy, 1'b0);
    read_at(8'h36, "R9 committed byte");
  endtask

  task automatic t_discard();
    load(8'h60); put(8'h11);
    load(8'h70);
    commit_wait("R2 discard", 0);
    chk("R2 ptr at new load", ptr, 8'h70);
  endtask

  task automatic t_hold();
    load(8'h83);
    repeat (20) @(negedge clk);
    chk("R10 ptr held", ptr, 8'h83);
    rd_byte_stb = 1'b1; @(negedge clk); rd_byte_stb = 1'b0;
    chk("R10 resumes from held", ptr, 8'h84);
  endtask

  initial begin
    m_ptr = '0;
    for (int i = 0; i < 16; i++) m_pv[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_small();
    t_page_wrap();
    t_partial();
    t_empty();
    t_read_wrap();
    t_busy_ignore();
    t_discard();
    t_hold();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule